// File: doc/BRIEF.md
# GPIO Port with Atomic Bit Operations

This block is an 8-bit general-purpose I/O port driven from a simple synchronous register bus. Software keeps an output data register and a direction register. Three extra write-only addresses change only chosen bits of the data register in a single bus write, with no read-modify-write sequence. One address sets bits, one clears bits and one inverts bits. Each changes only the bits whose write-data bit is one.

On the pin side the port drives the registered output value and a registered per-bit output enable. Read data is also registered. For each bit configured as an output, a read of the data address returns the latched output value. For each bit configured as an input, it returns the pin level after a two-flop synchronizer. A value written through any of the three bit-operation addresses can be read back from the data address on the cycle after the write.

Top module: `gpio_atomic_port`

## Requirements
- R1: Reset is synchronous and active high. Reset clears the data and direction registers, so `pin_oe` and `pin_out` are zero and every pin starts as an input.
- R2: A write to address 0 (data) loads `wr_data` into the data register. `pin_out` shows the new value after that clock edge.
- R3: A write to address 1 (direction) loads the direction register. A one bit means output. `pin_oe` shows the new value after that clock edge, and a read of address 1 returns it.
- R4: A write to address 2 (set) makes data = data OR `wr_data`.
- R5: A write to address 3 (clear) makes data = data AND NOT `wr_data`.
- R6: A write to address 4 (toggle) inverts exactly the data bits written as one. A pattern of zero changes nothing.
- R7: Reads of addresses 2, 3 and 4, and of the unmapped addresses 5 to 7, return zero and change nothing.
- R8: `rd_data` is registered. It holds the value of the address presented on the previous edge. A read that shares its edge with a data write returns the old value. A read on the cycle after a set, clear or toggle write returns the updated value.
- R9: A read of address 0 returns, for each bit, the latched output value when the direction bit is one. When the direction bit is zero, it returns `pin_in` delayed by two flops, so a pin change becomes visible to a read on the third edge after it.
- R10: Writes to the unmapped addresses 5 to 7 change neither the data nor the direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | 8 | Write data or bit pattern |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Registered output data to the pins |
| pin_oe | output | 8 | Registered per-bit output enable |

## Verification
A wrong data or direction bit appears on `pin_out` or `pin_oe` right after the clock edge that stored it. Every bit operation can therefore be judged at the pins with no delay. The readback path adds one register: a wrong read mux or a wrong per-bit direction select shows up one edge after the address is presented. A missing or extra synchronizer stage moves the first edge on which an input change is visible, and the bench checks both the read just before that edge and the read on it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Word addresses of the port registers
  localparam int unsigned OFF_DATA = 0;
  localparam int unsigned OFF_DIR  = 1;
  localparam int unsigned OFF_SET  = 2;
  localparam int unsigned OFF_CLR  = 3;
  localparam int unsigned OFF_TOG  = 4;
  localparam int unsigned MIN_ADDR_W = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q
);
  logic [WIDTH-1:0] data_nxt;
  logic [WIDTH-1:0] dir_nxt;

  always_comb begin
    data_nxt = data_q;
    dir_nxt  = dir_q;
    if (wr_en) begin
      case (addr)
        ADDR_W'(OFF_DATA): data_nxt = wr_data;
        ADDR_W'(OFF_DIR):  dir_nxt  = wr_data;
        ADDR_W'(OFF_SET):  data_nxt = data_q | wr_data;
        ADDR_W'(OFF_CLR):  data_nxt = data_q & ~wr_data;
        ADDR_W'(OFF_TOG):  data_nxt = data_q ^ wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_nxt;
      dir_q  <= dir_nxt;
    end
  end

  // R4: set alias ORs the pattern in
  a_r4_set_or: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_SET)) |=> data_q == ($past(data_q) | $past(wr_data)));
  // R5: clear alias masks the pattern out
  a_r5_clr_mask: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_CLR)) |=> data_q == ($past(data_q) & ~$past(wr_data)));
  // R6: toggle alias inverts only the ones
  a_r6_tog_xor: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_TOG)) |=> data_q == ($past(data_q) ^ $past(wr_data)));
  // R10: no write, no change
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(data_q) && $stable(dir_q)));
  // R10: unmapped writes change nothing
  a_r10_unmapped_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr > ADDR_W'(OFF_TOG)) |=> ($stable(data_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  data_q,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rd_data
);
  logic [WIDTH-1:0] pin_view;
  logic [WIDTH-1:0] rd_nxt;

  // per bit: latched value for outputs, synchronized pin for inputs
  assign pin_view = (data_q & dir_q) | (pin_sync & ~dir_q);

  always_comb begin
    case (addr)
      ADDR_W'(OFF_DATA): rd_nxt = pin_view;
      ADDR_W'(OFF_DIR):  rd_nxt = dir_q;
      default:           rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end

  // R7: alias and unmapped addresses read as zero
  a_r7_alias_zero: assert property (@(posedge clk) disable iff (rst)
    (addr > ADDR_W'(OFF_DIR)) |=> rd_data == '0);
  // R8: direction readback one edge later
  a_r8_dir_readback: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(OFF_DIR)) |=> rd_data == $past(dir_q));
endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .data_q(data_q), .dir_q(dir_q)
  );

  gpio_rd_mux #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .addr(addr), .data_q(data_q), .dir_q(dir_q),
    .pin_sync(pin_sync), .rd_data(rd_data)
  );

  assign pin_out = data_q;
  assign pin_oe  = dir_q;

  initial begin
    assert (ADDR_W >= MIN_ADDR_W) else $error("ADDR_W too small for register map");
  end

  // R1: reset leaves every pin an input with low output data
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && rd_data == '0));
  // R2: direct data write reaches the pins after one edge
  a_r2_direct_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_DATA)) |=> pin_out == $past(wr_data));
  // R3: direction write reaches the enables after one edge
  a_r3_dir_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_DIR)) |=> pin_oe == $past(wr_data));
endmodule

// File: tb/sim_gpio_atomic_port.sv
`timescale 1ns/1ps
module sim_gpio_atomic_port;
  localparam int W = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] addr;
  logic wr_en;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data;
  logic [W-1:0] pin_in;
  logic [W-1:0] pin_out;
  logic [W-1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_data = '0;
  logic [W-1:0] m_dir = '0;

  always #5 clk = ~clk;

  gpio_atomic_port #(.WIDTH(W), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    addr = AW'(a); wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    @(negedge clk);
    addr = AW'(a); wr_en = 1'b0;
    @(posedge clk); #1;
    d = rd_data;
  endtask

  function automatic logic [W-1:0] view(input logic [W-1:0] pins);
    return (m_data & m_dir) | (pins & ~m_dir);
  endfunction

  task automatic t_reset();
    logic [W-1:0] v;
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    rd(0, v); check("R1 data read", v, '0);
    rd(1, v); check("R1 dir read", v, '0);
  endtask

  task automatic t_dir_data();
    logic [W-1:0] v;
    wr(1, 8'hFF); m_dir = 8'hFF;
    check("R3 pin_oe", pin_oe, 8'hFF);
    rd(1, v); check("R3 dir read", v, 8'hFF);
    wr(0, 8'h3C); m_data = 8'h3C;
    check("R2 pin_out", pin_out, 8'h3C);
    rd(0, v); check("R2 data read", v, 8'h3C);
  endtask

  task automatic t_alias_ops();
    logic [W-1:0] v;
    wr(2, 8'h81); m_data = m_data | 8'h81;
    check("R4 set pin_out", pin_out, m_data);
    rd(0, v); check("R4 R8 set readback", v, m_data);
    wr(3, 8'h0F); m_data = m_data & ~8'h0F;
    check("R5 clear pin_out", pin_out, m_data);
    rd(0, v); check("R5 R8 clear readback", v, m_data);
    wr(4, 8'h55); m_data = m_data ^ 8'h55;
    check("R6 toggle pin_out", pin_out, m_data);
    rd(0, v); check("R6 R8 toggle readback", v, m_data);
    wr(4, 8'h00);
    check("R6 zero toggle", pin_out, m_data);
    wr(2, 8'h00);
    check("R4 zero set", pin_out, m_data);
    wr(3, 8'hFF); m_data = '0;
    check("R5 clear all", pin_out, 8'h00);
  endtask

  task automatic t_alias_reads();
    logic [W-1:0] v;
    wr(0, 8'hA7); m_data = 8'hA7;
    for (int a = 2; a < 8; a++) begin
      rd(a, v); check("R7 alias/unmapped read zero", v, '0);
    end
    check("R7 reads no side effect", pin_out, 8'hA7);
    rd(0, v); check("R7 data kept", v, 8'hA7);
  endtask

  task automatic t_unmapped_writes();
    logic [W-1:0] v;
    for (int a = 5; a < 8; a++) wr(a, 8'h5A);
    check("R10 data untouched", pin_out, m_data);
    check("R10 dir untouched", pin_oe, m_dir);
    rd(1, v); check("R10 dir read", v, m_dir);
  endtask

  task automatic t_same_cycle();
    logic [W-1:0] old;
    old = m_data;
    wr(0, 8'h19);
    check("R8 same-edge read old", rd_data, view('0) & 8'hFF);
    m_data = 8'h19;
    @(negedge clk); addr = AW'(0);
    @(posedge clk); #1;
    check("R8 next-edge read new", rd_data, 8'h19);
    if (old == 8'h19) check("R8 test pattern", 8'h00, 8'h01);
  endtask

  task automatic t_pins();
    logic [W-1:0] v;
    wr(1, 8'h0F); m_dir = 8'h0F;
    wr(0, 8'h3C); m_data = 8'h3C;
    @(negedge clk); pin_in = 8'hA5; addr = AW'(0);
    @(posedge clk); #1;
    check("R9 edge1 old pins", rd_data, view(8'h00));
    @(posedge clk); #1;
    check("R9 edge2 old pins", rd_data, view(8'h00));
    @(posedge clk); #1;
    check("R9 edge3 new pins", rd_data, view(8'hA5));
    check("R9 outputs keep latch", rd_data, 8'hAC);
    wr(1, 8'hF0); m_dir = 8'hF0;
    rd(0, v); check("R9 direction flip", v, 8'h35);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    m_data = '0; m_dir = '0;
    check("R1 reset clears oe", pin_oe, '0);
    check("R1 reset clears out", pin_out, '0);
  endtask

  initial begin
    rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_dir_data();
    t_alias_ops();
    t_alias_reads();
    t_unmapped_writes();
    t_same_cycle();
    t_pins();
    t_reset_again();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule